// File: doc/BRIEF.md
# Bitmap screen address calculator

This unit computes addresses and pixel masks for a memory-mapped bitmap display whose lines are stored in an interleaved order. The screen is split into three vertical thirds. Inside each third, eight character rows each hold eight pixel lines. Consecutive pixel lines sit 256 bytes apart, so the address of a line cannot be found by multiplying the row by a pitch. Drawing code hands the unit a pixel row and column, or an existing byte address. It gets back the byte address of that pixel, the address one line further down, or a one-hot mask for the pixel inside its byte.

Commands enter through a valid/ready handshake. `in_ready` is high while the unit is idle. A command is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` then drops and stays low until the result is complete, so a source must hold its command until it sees `in_ready`. A request made while `in_ready` is low is ignored and has no effect. The result registers are written when the command is accepted. A one-cycle `done` pulse marks the cycle in which the result is valid. `in_ready` is high again in that same cycle, so a new command can be accepted on the next edge. The unit therefore completes one command every `LATENCY` cycles. There is no output back-pressure: the results hold their values until the next accepted command.

Top module: `scr_addr_calc`

## Requirements
- R1: After reset, `out_addr` is 0x0000, `out_mask` is 0x00, `done` is 0 and `in_ready` is 1.
- R2: Operation code 0 (address) sets `out_addr` to 0x4000 plus a 13-bit offset. The offset has column bits 7:3 at bits 4:0, row bits 5:3 at bits 7:5, row bits 2:0 at bits 10:8 and row bits 7:6 at bits 12:11.
- R3: Operation code 1 (step down) with `addr_i` bits 10:8 not all ones sets `out_addr` to `addr_i` + 0x0100. In every step case, bits 4:0 are kept.
- R4: A step with bits 10:8 all ones and bits 7:5 not all ones clears bits 10:8 and then adds 0x0020.
- R5: A step with bits 10:8 and 7:5 all ones clears both fields and then adds 0x0800.
- R6: A step from the last line of the last third (0x57E0 to 0x57FF) gives 0x5800 to 0x581F. The result lies beyond the bitmap and is not wrapped back.
- R7: Operation code 2 (mask) sets `out_mask` to 0x80 shifted right by `col_i` bits 2:0, so a value of 0 selects bit 7.
- R8: `done` is high for exactly one cycle, `LATENCY` (default 8) cycles after the accepting edge.
- R9: `in_ready` is low from the cycle after acceptance until the `done` cycle. A request made while it is low is ignored and has no effect on the outputs or on `done`.
- R10: Operation code 3 is accepted and completes with a `done` pulse like any other command, but leaves both outputs unchanged.
- R11: The outputs change only on an accepting edge. The address and step operations leave `out_mask` unchanged, and the mask operation leaves `out_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Command request |
| in_ready | output | 1 | Unit idle and able to take a command |
| op_sel | input | 2 | 0 address, 1 step down, 2 mask, 3 no operation |
| row_i | input | 8 | Pixel row (0 to 191) |
| col_i | input | 8 | Pixel column (0 to 255) |
| addr_i | input | 16 | Byte address to step down |
| out_addr | output | 16 | Resulting byte address |
| out_mask | output | 8 | One-hot pixel mask |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
A command accepted on edge N writes `out_addr` and `out_mask` on that same edge. `done` is high between edges N+LATENCY-1 and N+LATENCY, and `in_ready` rises in that same window. The bench keeps a behavioural model that counts edges since acceptance and updates on every rising edge. Every falling edge compares all four outputs against the model, so each result is checked in the cycle it is due and in every cycle before and after. Explicit checks also chain each row's address through the step operation to the next row's address, covering all 192 rows.

// File: rtl/scr_pkg.sv
package scr_pkg;
  parameter int SCR_ADDR_W  = 16;
  parameter int SCR_COORD_W = 8;
  parameter int SCR_MASK_W  = 8;

  // Field positions of the interleaved layout (behaviour depends on them)
  parameter int LINE_LSB  = 8;   // pixel line within character row
  parameter int CROW_LSB  = 5;   // character row within third
  parameter int THIRD_LSB = 11;  // third of the screen

  typedef enum logic [1:0] {
    OP_ADDR = 2'd0,
    OP_STEP = 2'd1,
    OP_MASK = 2'd2,
    OP_NONE = 2'd3
  } scr_op_e;
endpackage

// File: rtl/scr_addr_map.sv
module scr_addr_map
  import scr_pkg::*;
#(
  parameter logic [SCR_ADDR_W-1:0] BASE = 16'h4000
) (
  input  logic [SCR_COORD_W-1:0] row,
  input  logic [SCR_COORD_W-1:0] col,
  output logic [SCR_ADDR_W-1:0]  addr
);
  localparam int OFS_W = THIRD_LSB + 2;

  logic [OFS_W-1:0] offset;

  // third | line in cell | character row | byte column
  assign offset = {row[7:6], row[2:0], row[5:3], col[7:3]};
  assign addr   = BASE + SCR_ADDR_W'(offset);
endmodule

// File: rtl/scr_line_step.sv
module scr_line_step
  import scr_pkg::*;
(
  input  logic [SCR_ADDR_W-1:0] addr_in,
  output logic [SCR_ADDR_W-1:0] addr_out
);
  localparam logic [SCR_ADDR_W-1:0] LINE_INC  = SCR_ADDR_W'(1) << LINE_LSB;
  localparam logic [SCR_ADDR_W-1:0] CROW_INC  = SCR_ADDR_W'(1) << CROW_LSB;
  localparam logic [SCR_ADDR_W-1:0] THIRD_INC = SCR_ADDR_W'(1) << THIRD_LSB;
  localparam logic [SCR_ADDR_W-1:0] LINE_CLR  = ~(SCR_ADDR_W'(7) << LINE_LSB);
  localparam logic [SCR_ADDR_W-1:0] CROW_CLR  = ~(SCR_ADDR_W'(7) << CROW_LSB);

  logic line_last;
  logic crow_last;

  assign line_last = &addr_in[LINE_LSB +: 3];
  assign crow_last = &addr_in[CROW_LSB +: 3];

  always_comb begin
    if (!line_last) begin
      addr_out = addr_in + LINE_INC;
    end else if (!crow_last) begin
      addr_out = (addr_in & LINE_CLR) + CROW_INC;
    end else begin
      addr_out = (addr_in & LINE_CLR & CROW_CLR) + THIRD_INC;
    end
  end
endmodule

// File: rtl/scr_pix_mask.sv
module scr_pix_mask
  import scr_pkg::*;
(
  input  logic [SCR_COORD_W-1:0] col,
  output logic [SCR_MASK_W-1:0]  mask
);
  localparam int SEL_W = $clog2(SCR_MASK_W);

  logic [SEL_W-1:0] sel;
  assign sel = col[SEL_W-1:0];

  // leftmost pixel sits in the most significant bit
  for (genvar i = 0; i < SCR_MASK_W; i++) begin : g_bit
    assign mask[i] = (sel == SEL_W'(SCR_MASK_W - 1 - i));
  end
endmodule

// File: rtl/scr_addr_calc.sv
module scr_addr_calc
  import scr_pkg::*;
#(
  parameter int LATENCY = 8,
  parameter logic [SCR_ADDR_W-1:0] BASE = 16'h4000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [1:0]             op_sel,
  input  logic [SCR_COORD_W-1:0] row_i,
  input  logic [SCR_COORD_W-1:0] col_i,
  input  logic [SCR_ADDR_W-1:0]  addr_i,
  output logic [SCR_ADDR_W-1:0]  out_addr,
  output logic [SCR_MASK_W-1:0]  out_mask,
  output logic                   done
);
  localparam int CNT_W = $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);

  logic                  busy_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  done_q;
  logic [SCR_ADDR_W-1:0] addr_q;
  logic [SCR_MASK_W-1:0] mask_q;
  logic                  accept;
  scr_op_e               op;

  logic [SCR_ADDR_W-1:0] map_addr;
  logic [SCR_ADDR_W-1:0] step_addr;
  logic [SCR_MASK_W-1:0] pix_mask;

  scr_addr_map #(.BASE(BASE)) u_map (
    .row (row_i),
    .col (col_i),
    .addr(map_addr)
  );

  scr_line_step u_step (
    .addr_in (addr_i),
    .addr_out(step_addr)
  );

  scr_pix_mask u_mask (
    .col (col_i),
    .mask(pix_mask)
  );

  assign op       = scr_op_e'(op_sel);
  assign in_ready = !busy_q;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      addr_q <= '0;
      mask_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_LOAD;
        unique case (op)
          OP_ADDR: addr_q <= map_addr;
          OP_STEP: addr_q <= step_addr;
          OP_MASK: mask_q <= pix_mask;
          default: ;
        endcase
      end else if (busy_q) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign out_addr = addr_q;
  assign out_mask = mask_q;
  assign done     = done_q;

  // Independent age counter used only by the latency assertion
  logic [CNT_W-1:0] chk_age_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_age_q <= CNT_W'(LATENCY);
    end else if (accept) begin
      chk_age_q <= '0;
    end else if (chk_age_q != CNT_W'(LATENCY)) begin
      chk_age_q <= chk_age_q + CNT_W'(1);
    end
  end

  assert_done_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (chk_age_q == CNT_W'(LATENCY - 1)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_reissue_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  assert_hold_outputs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(out_addr) && $stable(out_mask)));

  assert_mask_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mask != '0) |-> ($countones(out_mask) == 1));

  assert_step_keeps_column_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_sel == 2'd1) |=> (out_addr[CROW_LSB-1:0] == $past(addr_i[CROW_LSB-1:0])));
endmodule

// File: tb/scr_addr_calc_bench.sv
`timescale 1ns/1ps
module scr_addr_calc_bench;
  localparam int LAT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  op_sel = 2'd0;
  logic [7:0]  row_i = 8'd0;
  logic [7:0]  col_i = 8'd0;
  logic [15:0] addr_i = 16'd0;
  logic [15:0] out_addr;
  logic [7:0]  out_mask;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  scr_addr_calc #(.LATENCY(LAT)) u_scr_addr_calc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_sel(op_sel), .row_i(row_i), .col_i(col_i), .addr_i(addr_i),
    .out_addr(out_addr), .out_mask(out_mask), .done(done)
  );

  // ---------------- behavioural reference ----------------
  function automatic int ref_addr(int row, int col);
    return 16384 + (row / 64) * 2048 + (row % 8) * 256 + ((row / 8) % 8) * 32 + col / 8;
  endfunction

  function automatic int ref_step(int a);
    int line_no, crow;
    line_no = (a / 256) % 8;
    crow    = (a / 32) % 8;
    if (line_no != 7) return (a + 256) % 65536;
    if (crow != 7) return a - 7 * 256 + 32;
    return a - 7 * 256 - 7 * 32 + 2048;
  endfunction

  function automatic int ref_mask(int col);
    return 128 >> (col % 8);
  endfunction

  int m_age;
  int m_addr;
  int m_mask;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_age  <= LAT;
      m_addr <= 0;
      m_mask <= 0;
    end else if (in_valid && (m_age >= LAT - 1)) begin
      m_age <= 0;
      case (int'(op_sel))
        0: m_addr <= ref_addr(row_i, col_i);
        1: m_addr <= ref_step(addr_i);
        2: m_mask <= ref_mask(col_i);
        default: ;
      endcase
    end else if (m_age < LAT) begin
      m_age <= m_age + 1;
    end
  end

  task automatic check_val(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check_val("R8", "done", int'(done), int'(m_age == LAT - 1));
      check_val("R9", "in_ready", int'(in_ready), int'(m_age >= LAT - 1));
      check_val(cur_req, "out_addr", int'(out_addr), m_addr);
      check_val(cur_req, "out_mask", int'(out_mask), m_mask);
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(int op, int row, int col, int addr, string req);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    cur_req  = req;
    op_sel   = 2'(op);
    row_i    = 8'(row);
    col_i    = 8'(col);
    addr_i   = 16'(addr);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (LAT) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int row_addr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check_val("R1", "out_addr", int'(out_addr), 0);
    check_val("R1", "out_mask", int'(out_mask), 0);
    check_val("R1", "done", int'(done), 0);
    check_val("R1", "in_ready", int'(in_ready), 1);

    // R2 address conversion
    issue(0, 0, 0, 0, "R2");
    check_val("R2", "addr(0,0)", int'(out_addr), 16'h4000);
    issue(0, 191, 255, 0, "R2");
    check_val("R2", "addr(191,255)", int'(out_addr), 16'h57FF);
    issue(0, 8'h47, 8'h9A, 0, "R2");
    check_val("R2", "addr(0x47,0x9A)", int'(out_addr), ref_addr(8'h47, 8'h9A));

    // R7 masks, R11 mask leaves address
    for (int c = 0; c < 8; c++) begin
      issue(2, 0, c + 8 * c, 0, "R7");
      check_val("R7", "mask", int'(out_mask), 128 >> c);
      check_val("R11", "addr held", int'(out_addr), ref_addr(8'h47, 8'h9A));
    end

    // R3 R4 R5 R6 step cases
    issue(1, 0, 0, 16'h4000, "R3");
    check_val("R3", "step 0x4000", int'(out_addr), 16'h4100);
    check_val("R11", "mask held", int'(out_mask), 8'h01);
    issue(1, 0, 0, 16'h4713, "R4");
    check_val("R4", "step 0x4713", int'(out_addr), 16'h4033);
    issue(1, 0, 0, 16'h47E5, "R5");
    check_val("R5", "step 0x47E5", int'(out_addr), 16'h4805);
    issue(1, 0, 0, 16'h57E0, "R6");
    check_val("R6", "step 0x57E0", int'(out_addr), 16'h5800);
    issue(1, 0, 0, 16'h57FF, "R6");
    check_val("R6", "step 0x57FF", int'(out_addr), 16'h581F);

    // R10 no-op code leaves outputs
    issue(3, 12, 34, 16'h1234, "R10");
    check_val("R10", "addr held", int'(out_addr), 16'h581F);
    check_val("R10", "mask held", int'(out_mask), 8'h01);

    // R9 request held while busy is ignored
    @(negedge clk);
    cur_req = "R9";
    op_sel = 2'd0; row_i = 8'd5; col_i = 8'd40; in_valid = 1'b1;
    @(negedge clk);
    op_sel = 2'd2; col_i = 8'd3;
    repeat (LAT - 2) @(negedge clk);
    check_val("R9", "addr during busy", int'(out_addr), ref_addr(5, 40));
    check_val("R9", "mask during busy", int'(out_mask), 8'h01);
    @(negedge clk);  // done cycle: held request is taken on next edge
    @(negedge clk);
    in_valid = 1'b0;
    repeat (LAT) @(negedge clk);
    check_val("R9", "mask after reissue", int'(out_mask), 8'h10);

    // Row chain: step of each row equals next row (R3 R4 R5)
    for (int r = 0; r < 192; r++) begin
      issue(0, r, 8'hA8, 0, "R2");
      row_addr = int'(out_addr);
      issue(1, 0, 0, row_addr, "R5");
      if (r < 191) check_val("R4", "row chain", int'(out_addr), ref_addr(r + 1, 8'hA8));
      else check_val("R6", "past bitmap", int'(out_addr), 16'h5815);
    end

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule